// File: doc/BRIEF.md
# Flash Page-Program Transmit Buffer

This block sits between a host bus and a serial flash engine and holds the data for a page-program command. The host pushes 32-bit words into a small queue. The serial engine starts a command with a byte count and then requests one byte at a time. Each word is sent least significant byte first, and a word leaves the queue once its fourth byte has been taken.

The block watches how much data it still holds, counted in bytes. When a byte is requested while fewer than sixteen bytes (128 bits) remain, a sticky underrun flag is raised. When a byte is requested from an empty queue, the command is not stopped. It runs on to its full byte count, and every byte it delivers from then on is 0xFF. Data the host writes after that point stays in the queue for the next command. Software can then reprogram from the failing point without erasing the sector.

A command may only begin when at least four words are queued. A start request with too little data is refused and reported with a one-cycle pulse.

Top module: `pgm_txbuf`

## Requirements
- R1: A start request is accepted only while no command is running, at least four words are queued and the byte count is nonzero. Otherwise, when no command is running, `start_rej` pulses high for exactly one cycle, in the cycle after the request, and no command begins.
- R2: `not_full` is high exactly while fewer than DEPTH words are stored.
- R3: Each accepted pull returns one byte on `pull_byte` in the cycle after the pull. Bytes of a word come out from bits 7:0 up to bits 31:24, and the word is removed after its fourth byte.
- R4: An accepted pull sets `uflow` when the bytes held are fewer than 16. Bytes held means four times the stored words, minus the bytes already taken from the oldest word. This includes a pull made while the queue is empty.
- R5: `uflow` stays set until `uflow_clr` is high for a cycle. If a new underrun occurs in the same cycle as a clear, the flag stays set.
- R6: After a pull finds the queue empty, every later byte of that command is 0xFF, even if the host writes new words. Those words are kept, unconsumed, for the next command.
- R7: A command delivers exactly its byte count. `done` pulses for one cycle in the cycle after the last pull, and the block then goes idle. Pulls while idle are ignored: `pull_byte` keeps its value and no stored data is consumed.
- R8: A host write while DEPTH words are stored is dropped and leaves the stored words unchanged.
- R9: After reset: `not_full`=1, `uflow`=0, `done`=0, `start_rej`=0, `pull_byte`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host word write strobe |
| host_wdata | input | 32 | Host write word |
| cmd_start | input | 1 | Start a program command |
| cmd_len | input | LEN_W | Byte count of the command |
| pull | input | 1 | Serial side requests one byte |
| uflow_clr | input | 1 | Write-one-to-clear for the underrun flag |
| pull_byte | output | 8 | Byte delivered for the last accepted pull |
| not_full | output | 1 | Queue can take another word |
| uflow | output | 1 | Sticky underrun flag |
| done | output | 1 | One-cycle pulse when the command finishes |
| start_rej | output | 1 | One-cycle pulse for a refused start |

## Verification
The hardest state to reach is the all-ones substitution. It needs a command that is still running after the queue has drained, and then a host write that lands in the middle of that command. The stimulus queues exactly four words and starts a 24-byte command. It pulls through the sixteen real bytes and then one pull into the empty queue. It then writes a marker word mid-command and pulls the remaining bytes, all of which must be 0xFF. Finally it starts a fresh command and checks that the marker word comes out intact, least significant byte first.

// File: rtl/pgm_txbuf_pkg.sv
package pgm_txbuf_pkg;
  localparam int unsigned LANES      = 4;
  localparam int unsigned LOW_BYTES  = 16;  // 128-bit threshold
  localparam int unsigned MIN_WORDS  = 4;
  localparam logic [7:0]  FILL_BYTE  = 8'hFF;

  function automatic int unsigned held_bytes(int unsigned words, int unsigned taken);
    return words * LANES - taken;
  endfunction

  function automatic logic [7:0] lane_of(logic [31:0] w, logic [1:0] sel);
    return w[8*sel +: 8];
  endfunction
endpackage

// File: rtl/txb_store.sv
module txb_store #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [31:0]   wdata,
  input  logic          pop,
  output logic [31:0]   head,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_wr, do_pop;

  assign full   = (count == CW'(DEPTH));
  assign do_wr  = wr && !full;
  assign do_pop = pop && (count != '0);
  assign head   = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr)  wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      count <= count + CW'(do_wr) - CW'(do_pop);
    end
  end

  a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr && !pop) |=> (count == $past(count)));
  a_r2_write_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && wr && !pop) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/txb_cmd.sv
module txb_cmd #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  input  logic [LEN_W-1:0] start_len,
  input  logic             pull,
  input  logic             empty,
  output logic             busy,
  output logic             pull_acc,
  output logic             use_ff,
  output logic [1:0]       lane,
  output logic             pop,
  output logic             done
);
  logic [LEN_W-1:0] remain;
  logic             fill_q;
  logic             last_pull;

  assign pull_acc  = pull && busy;
  assign use_ff    = fill_q || empty;
  assign pop       = pull_acc && !use_ff && (lane == 2'd3);
  assign last_pull = pull_acc && (remain == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
      lane   <= '0;
      fill_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_ok) begin
        busy   <= 1'b1;
        remain <= start_len;
      end else if (pull_acc) begin
        remain <= remain - 1'b1;
        if (!use_ff) lane <= lane + 1'b1;
        if (empty)   fill_q <= 1'b1;
        if (last_pull) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          fill_q <= 1'b0;
        end
      end
    end
  end

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r3_lane_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_acc && !use_ff && lane == 2'd3) |=> (lane == 2'd0));
  a_r6_fill_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q && busy && !last_pull) |=> fill_q);
endmodule

// File: rtl/pgm_txbuf.sv
module pgm_txbuf
  import pgm_txbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [31:0]      host_wdata,
  input  logic             cmd_start,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             pull,
  input  logic             uflow_clr,
  output logic [7:0]       pull_byte,
  output logic             not_full,
  output logic             uflow,
  output logic             done,
  output logic             start_rej
);
  logic [31:0]   head;
  logic [CW-1:0] words;
  logic          full, empty, busy, pull_acc, use_ff, pop, start_ok, low_water;
  logic [1:0]    lane;

  assign empty     = (words == '0);
  assign not_full  = !full;
  assign start_ok  = cmd_start && !busy && (32'(words) >= MIN_WORDS) && (cmd_len != '0);
  assign low_water = held_bytes(32'(words), 32'(lane)) < LOW_BYTES;

  txb_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .wdata(host_wdata),
    .pop(pop), .head(head), .count(words), .full(full)
  );

  txb_cmd #(.LEN_W(LEN_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .start_len(cmd_len),
    .pull(pull), .empty(empty), .busy(busy), .pull_acc(pull_acc),
    .use_ff(use_ff), .lane(lane), .pop(pop), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pull_byte <= '0;
      uflow     <= 1'b0;
      start_rej <= 1'b0;
    end else begin
      start_rej <= cmd_start && !busy && !start_ok;
      if (pull_acc) pull_byte <= use_ff ? FILL_BYTE : lane_of(head, lane);
      if (pull_acc && low_water) uflow <= 1'b1;
      else if (uflow_clr)        uflow <= 1'b0;
    end
  end

  a_r6_ff_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_acc && use_ff) |=> (pull_byte == 8'hFF));
  a_r4_low_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_acc && empty) |=> uflow);
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !uflow_clr) |=> uflow);
  a_r1_short_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !busy && words < CW'(MIN_WORDS)) |=> (start_rej && !busy));
  a_r7_idle_pull: assert property (@(posedge clk) disable iff (!rst_n)
    (pull && !busy && !cmd_start) |=> $stable(pull_byte));
endmodule

// File: tb/tb_pgm_txbuf.sv
module tb_pgm_txbuf;
  localparam int DEPTH = 16;
  localparam int LEN_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, cmd_start = 0, pull = 0, uflow_clr = 0;
  logic [31:0] host_wdata = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [7:0] pull_byte;
  logic not_full, uflow, done, start_rej;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  localparam logic [31:0] VEC [8] = '{
    32'h0403_0201, 32'h8877_6655, 32'hDEAD_BEEF, 32'h0000_00FF,
    32'hF00D_CAFE, 32'h1234_5678, 32'hA5A5_5A5A, 32'h7F80_01FE };

  always #4 clk = ~clk;

  pgm_txbuf #(.DEPTH(DEPTH), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .cmd_start(cmd_start), .cmd_len(cmd_len), .pull(pull), .uflow_clr(uflow_clr),
    .pull_byte(pull_byte), .not_full(not_full), .uflow(uflow), .done(done),
    .start_rej(start_rej));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [31:0] w);
    @(negedge clk); host_wr = 1; host_wdata = w;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic do_start(input int len);
    @(negedge clk); cmd_start = 1; cmd_len = LEN_W'(len);
    @(negedge clk); cmd_start = 0;
  endtask

  task automatic pull_one;
    @(negedge clk); pull = 1;
    @(negedge clk); pull = 0;
  endtask

  function automatic logic [7:0] byte_of(logic [31:0] w, int k);
    return w[8*k +: 8];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] fw [4];
    logic [31:0] xw;
    logic [31:0] qw [16];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 not_full", 32'(not_full), 1);
    chk("R9 uflow", 32'(uflow), 0);
    chk("R9 done", 32'(done), 0);
    chk("R9 start_rej", 32'(start_rej), 0);
    chk("R9 pull_byte", 32'(pull_byte), 0);

    // R1 start with empty queue refused; R7 idle pull ignored
    do_start(8);
    chk("R1 reject empty", 32'(start_rej), 1);
    @(negedge clk);
    chk("R1 reject one cycle", 32'(start_rej), 0);
    pull_one;
    chk("R7 idle pull byte", 32'(pull_byte), 0);
    chk("R7 idle pull done", 32'(done), 0);

    // R1 three words is too few
    for (int i = 0; i < 3; i++) wr_word(VEC[i]);
    do_start(32);
    chk("R1 reject three words", 32'(start_rej), 1);
    pull_one;
    chk("R7 idle pull after reject", 32'(pull_byte), 0);

    // Table walk: R3 ordering, R4 threshold, R7 completion
    for (int i = 3; i < 8; i++) wr_word(VEC[i]);
    do_start(32);
    chk("R1 accept", 32'(start_rej), 0);
    for (int k = 0; k < 32; k++) begin
      pull_one;
      chk("R3 byte order", 32'(pull_byte), 32'(byte_of(VEC[k/4], k%4)));
      if (k == 16) chk("R4 sixteen held no flag", 32'(uflow), 0);
      if (k == 17) chk("R4 fifteen held flags", 32'(uflow), 1);
      chk("R7 done timing", 32'(done), (k == 31) ? 1 : 0);
    end
    @(negedge clk);
    chk("R7 done single", 32'(done), 0);
    pull_one;
    chk("R7 pull after done ignored", 32'(pull_byte), 32'(byte_of(VEC[7], 3)));

    // R5 sticky then cleared
    repeat (3) @(negedge clk);
    chk("R5 sticky", 32'(uflow), 1);
    uflow_clr = 1; @(negedge clk); uflow_clr = 0;
    chk("R5 cleared", 32'(uflow), 0);

    // R6 fill mode
    for (int i = 0; i < 4; i++) begin fw[i] = 32'h1020_3040 + 32'(i) * 32'h0101_0101; wr_word(fw[i]); end
    do_start(24);
    for (int k = 0; k < 16; k++) begin
      pull_one;
      chk("R3 fill-test data", 32'(pull_byte), 32'(byte_of(fw[k/4], k%4)));
      if (k == 1) chk("R4 low water flag", 32'(uflow), 1);
    end
    uflow_clr = 1; @(negedge clk); uflow_clr = 0;
    pull_one;
    chk("R6 empty pull gives FF", 32'(pull_byte), 32'hFF);
    chk("R4 empty pull flags", 32'(uflow), 1);
    xw = 32'h5A5A_A5C3;
    wr_word(xw);
    for (int k = 17; k < 24; k++) begin
      pull_one;
      chk("R6 FF after host write", 32'(pull_byte), 32'hFF);
      chk("R7 done on count", 32'(done), (k == 23) ? 1 : 0);
    end
    for (int i = 0; i < 3; i++) begin qw[i] = 32'h1100_0000 + 32'(i); wr_word(qw[i]); end
    do_start(4);
    chk("R1 accept four", 32'(start_rej), 0);
    for (int k = 0; k < 4; k++) begin
      pull_one;
      chk("R6 kept word intact", 32'(pull_byte), 32'(byte_of(xw, k)));
    end

    // R8/R2 full queue, dropped write
    for (int i = 3; i < 16; i++) begin
      qw[i] = {8'(i), 8'(i+1), 8'(i+2), 8'(i+3)} ^ 32'hA0B0_C0D0;
      wr_word(qw[i]);
    end
    chk("R2 full clears not_full", 32'(not_full), 0);
    wr_word(32'hDEAD_0BAD);
    chk("R8 still full", 32'(not_full), 0);
    do_start(0);
    chk("R1 zero length refused", 32'(start_rej), 1);
    do_start(64);
    for (int k = 0; k < 64; k++) begin
      pull_one;
      chk("R8 contents intact", 32'(pull_byte), 32'(byte_of(qw[k/4], k%4)));
      if (k == 2) chk("R2 not_full before pop", 32'(not_full), 0);
      if (k == 3) chk("R2 not_full after pop", 32'(not_full), 1);
      if (k == 63) chk("R7 final done", 32'(done), 1);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule